// File: doc/BRIEF.md
# Circuit Setup and Reconfiguration Unit

This unit sits in each router of a 4x4 mesh network on chip that carries several parallel circuit planes beside its packet-switched fabric. It accepts narrow setup messages from a lightweight, buffered setup network that has no virtual channels. Each message names a circuit plane and a destination node. The unit routes the message to an output port with dimension-ordered XY routing, claims a plane on that output, and records which input port owns the plane. It then forwards the message, with the plane it actually granted, to the next hop.

Setup is never acknowledged and never stalls for lack of a free link. The first data transfer therefore travels alongside the setup. When the requested plane on the chosen output is taken, the unit grants the lowest free plane instead. When every plane on that output is held, a per-output round-robin pointer picks a victim plane. The unit overwrites that entry and raises a one-cycle invalidate pulse naming the evicted input, output and plane, so the former owner falls back to packet switching. The data crossbar reads the stored configuration through a plain lookup port.

The setup input and the forwarded output are valid/ready streams with one output register between them. A message is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the forwarded message holds still and no new message is accepted.

Top module: `circ_setup_unit`

## Requirements
- R1: During and right after reset, `out_valid` and `inv_valid` are 0, `in_ready` is 1, and every lookup returns `q_valid` = 0.
- R2: With node coordinates X = `in_msg[1:0]`, Y = `in_msg[3:2]` and port codes local=0, north=1, east=2, south=3, west=4, the output is chosen as follows, with X compared first: a larger X routes east and a smaller X routes west. Otherwise a larger Y routes south and a smaller Y routes north. The router's own node routes local.
- R3: A setup message is 6 bits: the requested plane in bits [5:4] and the destination in bits [3:0]. The forwarded `out_msg[3:0]` equals the accepted destination.
- R4: If the requested plane is free on the chosen output, it is granted and written into `out_msg[5:4]`. If it is held but another plane is free, the lowest-numbered free plane is granted instead.
- R5: If all planes on the chosen output are held, the plane named by that output's round-robin pointer is granted. The pointer starts at 0 after reset and steps by one, wrapping at the plane count, after each eviction on that output.
- R6: On an eviction, `inv_valid` is high for exactly the cycle in which the forwarded message first appears. `inv_inport` carries the evicted owner's input port, and `inv_outport`/`inv_plane` carry the output and plane taken over.
- R7: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_port` and `out_msg` stay unchanged.
- R8: The forwarded message appears on `out_valid` one cycle after acceptance. From that same cycle on, a lookup of (`q_out`, `q_plane`) returns `q_valid` = 1 and `q_inport` = the accepting `in_port`.
- R9: `inv_valid` stays low when a setup is granted without an eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Setup message present |
| in_ready | output | 1 | Unit can accept a setup message |
| in_port | input | 3 | Input port the setup arrived on |
| in_msg | input | 6 | Setup message {plane, destination} |
| out_valid | output | 1 | Forwarded setup message present |
| out_ready | input | 1 | Next hop takes the forwarded message |
| out_port | output | 3 | Output port chosen by routing |
| out_msg | output | 6 | Forwarded message {granted plane, destination} |
| inv_valid | output | 1 | One-cycle eviction pulse |
| inv_inport | output | 3 | Input port of the evicted circuit |
| inv_outport | output | 3 | Output port of the evicted circuit |
| inv_plane | output | 2 | Plane of the evicted circuit |
| q_out | input | 3 | Lookup output port |
| q_plane | input | 2 | Lookup plane |
| q_valid | output | 1 | Lookup entry holds a circuit |
| q_inport | output | 3 | Lookup entry's owning input port |

## Verification
Every result of an accepted setup is due one clock edge after acceptance: the forwarded message, the invalidate pulse, and the updated table entry seen through the combinational lookup port. `in_ready` follows `out_valid` and `out_ready` in the same cycle. The bench's reference model advances on the rising edge from the inputs the bench drove at the previous falling edge. At each falling edge, before any input changes, the bench compares every output, including the lookup result for a sweeping query address, against the model's state for that cycle. Directed runs fill all planes on one output to force the lowest-free fallback, back-to-back evictions and stalls. A long pseudo-random phase follows.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int NUM_PORTS = 5;
  localparam int PORT_W    = 3;
  localparam int COORD_W   = 2;
  localparam int NODE_W    = 2 * COORD_W;
  localparam int PLF_W     = 2;
  localparam int MSG_W     = PLF_W + NODE_W;

  typedef enum logic [PORT_W-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_EAST  = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;
endpackage

// File: rtl/cs_xy_route.sv
module cs_xy_route
  import csu_pkg::*;
#(
  parameter int NODE_X = 1,
  parameter int NODE_Y = 2
) (
  input  logic [NODE_W-1:0] dest,
  output port_e             port
);
  localparam logic [COORD_W-1:0] MY_X = COORD_W'(NODE_X);
  localparam logic [COORD_W-1:0] MY_Y = COORD_W'(NODE_Y);

  logic [COORD_W-1:0] dx, dy;
  assign dx = dest[COORD_W-1:0];
  assign dy = dest[NODE_W-1:COORD_W];

  always_comb begin
    if (dx > MY_X)      port = PORT_EAST;
    else if (dx < MY_X) port = PORT_WEST;
    else if (dy > MY_Y) port = PORT_SOUTH;
    else if (dy < MY_Y) port = PORT_NORTH;
    else                port = PORT_LOCAL;
  end
endmodule

// File: rtl/cs_plane_pick.sv
module cs_plane_pick #(
  parameter int PLANES = 4,
  parameter int PW     = $clog2(PLANES)
) (
  input  logic [PLANES-1:0] busy,
  input  logic [PW-1:0]     req,
  input  logic [PW-1:0]     rr,
  output logic [PW-1:0]     pick,
  output logic              evict
);
  always_comb begin
    pick  = req;
    evict = 1'b0;
    if (busy[req]) begin
      if (&busy) begin
        pick  = rr;
        evict = 1'b1;
      end else begin
        for (int i = PLANES - 1; i >= 0; i--) begin
          if (!busy[i]) pick = PW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/cs_circuit_table.sv
module cs_circuit_table
  import csu_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int PW     = $clog2(PLANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] lk_out,
  input  logic [PW-1:0]     lk_plane,
  output logic [PLANES-1:0] lk_busy,
  output logic [PW-1:0]     lk_rr,
  output logic [PORT_W-1:0] lk_owner,
  input  logic              wr_en,
  input  logic              wr_evict,
  input  logic [PW-1:0]     wr_plane,
  input  logic [PORT_W-1:0] wr_inport,
  input  logic [PORT_W-1:0] q_out,
  input  logic [PW-1:0]     q_plane,
  output logic              q_valid,
  output logic [PORT_W-1:0] q_inport
);
  localparam int ENTRIES = NUM_PORTS * PLANES;

  logic [ENTRIES-1:0]        vld_flat;
  logic [ENTRIES*PORT_W-1:0] own_flat;
  logic [NUM_PORTS*PW-1:0]   rr_flat;

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    logic [PLANES-1:0]        vld_q;
    logic [PLANES*PORT_W-1:0] own_q;
    logic [PW-1:0]            rr_q;
    logic                     hit;

    assign hit = wr_en && (lk_out == PORT_W'(gp));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
        own_q <= '0;
        rr_q  <= '0;
      end else if (hit) begin
        vld_q[wr_plane]                <= 1'b1;
        own_q[wr_plane*PORT_W +: PORT_W] <= wr_inport;
        if (wr_evict) begin
          rr_q <= (rr_q == PW'(PLANES - 1)) ? '0 : rr_q + 1'b1;
        end
      end
    end

    assign vld_flat[gp*PLANES +: PLANES]               = vld_q;
    assign own_flat[gp*PLANES*PORT_W +: PLANES*PORT_W] = own_q;
    assign rr_flat[gp*PW +: PW]                        = rr_q;
  end

  always_comb begin
    lk_busy  = '0;
    lk_rr    = '0;
    lk_owner = '0;
    q_valid  = 1'b0;
    q_inport = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (lk_out == PORT_W'(p)) begin
        lk_busy  = vld_flat[p*PLANES +: PLANES];
        lk_rr    = rr_flat[p*PW +: PW];
        lk_owner = own_flat[(p*PLANES + int'(lk_plane))*PORT_W +: PORT_W];
      end
      if (q_out == PORT_W'(p)) begin
        q_valid  = vld_flat[p*PLANES + int'(q_plane)];
        q_inport = own_flat[(p*PLANES + int'(q_plane))*PORT_W +: PORT_W];
      end
    end
  end
endmodule

// File: rtl/circ_setup_unit.sv
module circ_setup_unit
  import csu_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int NODE_X = 1,
  parameter int NODE_Y = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PORT_W-1:0] in_port,
  input  logic [MSG_W-1:0]  in_msg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PORT_W-1:0] out_port,
  output logic [MSG_W-1:0]  out_msg,
  output logic              inv_valid,
  output logic [PORT_W-1:0] inv_inport,
  output logic [PORT_W-1:0] inv_outport,
  output logic [PLF_W-1:0]  inv_plane,
  input  logic [PORT_W-1:0] q_out,
  input  logic [PLF_W-1:0]  q_plane,
  output logic              q_valid,
  output logic [PORT_W-1:0] q_inport
);
  localparam int PW = $clog2(PLANES);

  logic              accept;
  port_e             route;
  logic [PLANES-1:0] busy;
  logic [PW-1:0]     rr;
  logic [PW-1:0]     pick;
  logic              evict;
  logic [PORT_W-1:0] owner;
  logic [PLF_W-1:0]  pick_f;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  cs_xy_route #(.NODE_X(NODE_X), .NODE_Y(NODE_Y)) u_route (
    .dest (in_msg[NODE_W-1:0]),
    .port (route)
  );

  cs_plane_pick #(.PLANES(PLANES), .PW(PW)) u_pick (
    .busy  (busy),
    .req   (in_msg[NODE_W +: PW]),
    .rr    (rr),
    .pick  (pick),
    .evict (evict)
  );

  cs_circuit_table #(.PLANES(PLANES), .PW(PW)) u_table (
    .clk       (clk),
    .rst       (rst),
    .lk_out    (route),
    .lk_plane  (pick),
    .lk_busy   (busy),
    .lk_rr     (rr),
    .lk_owner  (owner),
    .wr_en     (accept),
    .wr_evict  (evict),
    .wr_plane  (pick),
    .wr_inport (in_port),
    .q_out     (q_out),
    .q_plane   (q_plane[PW-1:0]),
    .q_valid   (q_valid),
    .q_inport  (q_inport)
  );

  always_comb begin
    pick_f         = '0;
    pick_f[PW-1:0] = pick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_port    <= '0;
      out_msg     <= '0;
      inv_valid   <= 1'b0;
      inv_inport  <= '0;
      inv_outport <= '0;
      inv_plane   <= '0;
    end else begin
      inv_valid <= 1'b0;
      if (out_ready) out_valid <= 1'b0;
      if (accept) begin
        out_valid   <= 1'b1;
        out_port    <= route;
        out_msg     <= {pick_f, in_msg[NODE_W-1:0]};
        inv_valid   <= evict;
        inv_inport  <= owner;
        inv_outport <= route;
        inv_plane   <= pick_f;
      end
    end
  end
endmodule

// File: rtl/circ_setup_unit_chk.sv
module circ_setup_unit_chk #(
  parameter int NODE_X = 1,
  parameter int NODE_Y = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [2:0] out_port,
  input logic [5:0] out_msg,
  input logic       inv_valid,
  input logic [2:0] inv_outport,
  input logic [1:0] inv_plane
);
  localparam logic [3:0] MY_ID = {NODE_Y[1:0], NODE_X[1:0]};

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && !inv_valid)); // R1

  AST_LOCAL_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_msg[3:0] == MY_ID) |-> (out_port == 3'd0)); // R2

  AST_INV_MATCH: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (inv_outport == out_port && inv_plane == out_msg[5:4])); // R5

  AST_INV_WITH_OUT: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> out_valid); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_msg) && $stable(out_port))); // R7

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R8

  AST_INV_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> $past(in_valid && in_ready)); // R9
endmodule

bind circ_setup_unit circ_setup_unit_chk #(.NODE_X(NODE_X), .NODE_Y(NODE_Y)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_port    (out_port),
  .out_msg     (out_msg),
  .inv_valid   (inv_valid),
  .inv_outport (inv_outport),
  .inv_plane   (inv_plane)
);

// File: tb/circ_setup_unit_bench.sv
module circ_setup_unit_bench;
  localparam int PLANES = 4;
  localparam int NX = 1;
  localparam int NY = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_ready;
  logic [2:0] in_port = '0;
  logic [5:0] in_msg = '0;
  logic       out_valid, out_ready = 1'b1;
  logic [2:0] out_port;
  logic [5:0] out_msg;
  logic       inv_valid;
  logic [2:0] inv_inport, inv_outport;
  logic [1:0] inv_plane;
  logic [2:0] q_out = '0;
  logic [1:0] q_plane = '0;
  logic       q_valid;
  logic [2:0] q_inport;

  circ_setup_unit #(.PLANES(PLANES), .NODE_X(NX), .NODE_Y(NY)) u_circ_setup_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_port(in_port), .in_msg(in_msg), .out_valid(out_valid),
    .out_ready(out_ready), .out_port(out_port), .out_msg(out_msg),
    .inv_valid(inv_valid), .inv_inport(inv_inport), .inv_outport(inv_outport),
    .inv_plane(inv_plane), .q_out(q_out), .q_plane(q_plane),
    .q_valid(q_valid), .q_inport(q_inport)
  );

  int n_cmp = 0, n_bad = 0;
  bit m_vld [5][PLANES];
  int m_own [5][PLANES];
  int m_rr [5];
  bit e_ov, e_inv, acc_last;
  int e_port, e_msg, e_ii, e_io, e_ip;
  int cyc = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int route(int d);
    int dx = d % 4;
    int dy = d / 4;
    if (dx > NX) return 2;
    if (dx < NX) return 4;
    if (dy > NY) return 3;
    if (dy < NY) return 1;
    return 0;
  endfunction

  // reference model, advanced on the rising edge
  always @(posedge clk) begin
    bit acc, found;
    int o, req, pick;
    if (rst) begin
      foreach (m_vld[i, j]) begin m_vld[i][j] = 0; m_own[i][j] = 0; end
      foreach (m_rr[i]) m_rr[i] = 0;
      e_ov = 0; e_inv = 0; acc_last = 0;
    end else begin
      acc = in_valid && (!e_ov || out_ready);
      acc_last = acc;
      e_inv = 0;
      if (out_ready) e_ov = 0;
      if (acc) begin
        o = route(int'(in_msg[3:0]));
        req = int'(in_msg[5:4]) % PLANES;
        pick = req;
        if (m_vld[o][req]) begin
          found = 0;
          for (int p = 0; p < PLANES; p++)
            if (!found && !m_vld[o][p]) begin pick = p; found = 1; end
          if (!found) begin
            pick = m_rr[o];
            e_inv = 1; e_ii = m_own[o][pick]; e_io = o; e_ip = pick;
            m_rr[o] = (m_rr[o] + 1) % PLANES;
          end
        end
        m_vld[o][pick] = 1;
        m_own[o][pick] = int'(in_port);
        e_ov = 1; e_port = o;
        e_msg = pick * 16 + int'(in_msg[3:0]);
      end
    end
  end

  task automatic compare();
    chk("R7 in_ready", int'(in_ready), int'(!e_ov || out_ready));
    chk("R8 out_valid", int'(out_valid), int'(e_ov));
    if (e_ov) begin
      chk("R2 out_port", int'(out_port), e_port);
      chk("R3 out_msg dest", int'(out_msg[3:0]), e_msg % 16);
      chk("R4 out_msg plane", int'(out_msg[5:4]), e_msg / 16);
    end
    if (e_inv) begin
      chk("R6 inv_valid", int'(inv_valid), 1);
      chk("R6 inv_inport", int'(inv_inport), e_ii);
      chk("R6 inv_outport", int'(inv_outport), e_io);
      chk("R5 inv_plane", int'(inv_plane), e_ip);
    end else begin
      chk("R9 inv_valid", int'(inv_valid), 0);
    end
    chk("R8 q_valid", int'(q_valid), int'(m_vld[q_out][q_plane]));
    if (m_vld[q_out][q_plane])
      chk("R8 q_inport", int'(q_inport), m_own[q_out][q_plane]);
  endtask

  function automatic logic [12:0] mk(int rdy, int v, int ip, int pl, int dest);
    return {1'(rdy), 1'(v), 3'(ip), 2'b00, 2'(pl), 4'(dest)};
  endfunction

  logic [12:0] stim[$];
  int unsigned lcg = 32'h1234_5678;

  // watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [12:0] s;
    // R1: reset state
    repeat (2) @(negedge clk);
    for (int o = 0; o < 5; o++)
      for (int p = 0; p < PLANES; p++) begin
        q_out = 3'(o); q_plane = 2'(p);
        #1;
        chk("R1 q_valid in reset", int'(q_valid), 0);
      end
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 inv_valid", int'(inv_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    @(negedge clk);
    rst = 1'b0;

    // R4: fill east output (dest x=3,y=2 -> 11) from west, requested plane 1
    for (int k = 0; k < 4; k++) stim.push_back(mk(1, 1, 4, 1, 11));
    // R5/R6: evictions on east
    stim.push_back(mk(1, 1, 1, 2, 11));
    stim.push_back(mk(0, 1, 3, 0, 11));
    stim.push_back(mk(0, 1, 0, 3, 11));
    stim.push_back(mk(1, 0, 0, 0, 0));
    // R2: other directions
    stim.push_back(mk(1, 1, 0, 0, 0));   // west
    stim.push_back(mk(1, 1, 2, 3, 1));   // north
    stim.push_back(mk(1, 1, 1, 2, 13));  // south
    stim.push_back(mk(1, 1, 3, 1, 9));   // local
    stim.push_back(mk(1, 1, 4, 0, 2));   // east, X first
    stim.push_back(mk(0, 1, 4, 0, 2));   // stall R7
    stim.push_back(mk(0, 0, 0, 0, 0));
    for (int k = 0; k < 3000; k++) begin
      lcg = lcg * 1103515245 + 12345;
      stim.push_back(mk(int'(lcg[20:19] != 2'b00), int'(lcg[22]), int'(lcg[27:25]) % 5,
                        int'(lcg[30:29]), int'(lcg[17:14])));
    end
    for (int k = 0; k < 25; k++) stim.push_back(mk(1, 0, 0, 0, 0));

    while (stim.size() > 0) begin
      @(negedge clk);
      compare();
      q_out = 3'((cyc / 4) % 5);
      q_plane = 2'(cyc % PLANES);
      if (!in_valid || acc_last) begin
        s = stim.pop_front();
        out_ready = s[12];
        in_valid  = s[11];
        in_port   = s[10:8];
        in_msg    = s[5:0];
      end else begin
        out_ready = 1'b1;
      end
    end
    @(negedge clk);
    compare();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule